// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Overrun Tagging

This block is the receive-side byte queue of a serial HDLC controller. The deframer pushes data bytes and end-of-frame status bytes into it. The host takes bytes out one at a time with a read strobe. The block tracks how many bytes are stored. It raises a threshold event each time that number climbs up to a programmable level.

When the deframer writes into a full queue, the block does not drop the byte quietly. It overwrites the newest stored entry with the deframer's current status value, with the overrun bit forced on. It then marks overrun as pending and ignores all receive writes until the host has done two things: read the status register and removed at least one byte. The two may come in either order. Both pending conditions go to one interrupt line, and a per-bit enable mask gates each of them.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: Bytes come out in the order they were accepted. `level` reports the number of stored bytes, from 0 to 64 (`DEPTH`). A read strobe on a non-empty queue places the oldest byte on `rd_data` in the cycle after the strobe.
- R2: When a byte is accepted and a byte is removed in the same cycle, both take effect and `level` does not change.
- R3: A read strobe on an empty queue sets `rd_data` to 0x00 and leaves `level` at 0. It does not count toward clearing overrun.
- R4: A write that arrives while the queue is full, with no removal in that cycle, replaces the newest stored entry with `sf_status` OR 0x20. This happens whether that entry was data or status. `level` stays at 64.
- R5: While overrun is pending, every receive write is discarded and leaves `level` unchanged.
- R6: Overrun appears as bit 5 of `irq_status`. It clears only in the cycle in which both of these have happened since it was set: a status read (`stat_rd`) and a removal from a non-empty queue. The two may come in either order.
- R7: Bit 3 of `irq_status` is set in every cycle in which `level` rises from below `thr_level` to `thr_level` or above. This includes a rise that follows a read which took the count below the level. A level of 0 never sets it. A status read clears the bit, but a new event in the same cycle wins.
- R8: `irq` is high exactly when (status bit 3 AND `irq_en[3]`) OR (status bit 5 AND `irq_en[5]`) holds. All other status bits read as 0.
- R9: After reset, `level` is 0, `irq_status` is 0x00, `irq` is low and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receive write strobe from the deframer |
| wr_data | input | 8 | Byte to store |
| sf_status | input | 8 | Current frame status value, used for the overrun substitute |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Byte returned by the last read strobe |
| stat_rd | input | 1 | Host read of the interrupt status register |
| irq_status | output | 8 | Pending events: bit 3 threshold, bit 5 overrun |
| irq_en | input | 8 | Interrupt enable mask, same bit positions |
| thr_level | input | 7 | Threshold level in bytes |
| level | output | 7 | Number of stored bytes |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions are evaluated on every cycle and cover these invariants:
- `level` never exceeds the depth.
- A combined push and pop keeps the count.
- An empty read leaves the queue empty.
- Discarded writes leave the count alone while overrun is pending.
- Overrun is only ever set on a full queue and never drops without a removal and a status read.
- A threshold event always leaves its status bit set.

Some behaviours can be shown only by the bench's scenarios, which compare against a queue model every clock:
- byte order through the queue;
- the value 0xB0 that ends up in the newest slot after an overflow with status 0x90;
- both orders of the overrun clear sequence;
- renewed threshold events after a read-then-write dip;
- masking of each interrupt source.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned THR_BIT = 3;
   localparam int unsigned OVR_BIT = 5;

   function automatic logic [BYTE_W-1:0] ovr_tag(input logic [BYTE_W-1:0] sf);
      logic [BYTE_W-1:0] t;
      t = sf;
      t[OVR_BIT] = 1'b1;
      return t;
   endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned DW        = 8,
   parameter int unsigned DEPTH     = 64,
   parameter bit          RESET_MEM = 1'b0,
   localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          rd_en,
   input  logic          ovr_wr,
   input  logic [DW-1:0] wr_data,
   input  logic [DW-1:0] ovr_val,
   output logic [DW-1:0] rd_q
);
   logic [AW-1:0] wp, rp, wp_prev;
   logic [DW-1:0] mem [DEPTH];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign wp_prev = (wp == '0) ? AW'(DEPTH - 1) : wp - AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         rd_q <= '0;
      end else begin
         if (push) wp <= bump(wp);
         if (pop)  rp <= bump(rp);
         if (rd_en) rd_q <= pop ? mem[rp] : '0;
      end
   end

   generate
      if (RESET_MEM) begin : g_mem_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (push) begin
               mem[wp] <= wr_data;
            end else if (ovr_wr) begin
               mem[wp_prev] <= ovr_val;
            end
         end
      end else begin : g_mem_plain
         always_ff @(posedge clk) begin
            if (push)        mem[wp]      <= wr_data;
            else if (ovr_wr) mem[wp_prev] <= ovr_val;
         end
      end
   endgenerate

   a_r4_ovr_excl_push: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_wr |-> !push)
      else $error("overwrite and push in the same cycle");
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [CW-1:0] thr,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          thr_evt
);
   logic [CW-1:0] cnt_nx;

   always_comb begin
      cnt_nx = count;
      if (push && !pop)      cnt_nx = count + CW'(1);
      else if (pop && !push) cnt_nx = count - CW'(1);
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign thr_evt = (thr != '0) && (count < thr) && (cnt_nx >= thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= cnt_nx;
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH))
      else $error("count above depth");

   a_r2_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop) |=> $stable(count))
      else $error("push+pop changed count");
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
   import rxq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              thr_evt,
   input  logic              ovr_set,
   input  logic              pop,
   input  logic              stat_rd,
   input  logic [BYTE_W-1:0] en,
   output logic [BYTE_W-1:0] stat,
   output logic              ovr_pend,
   output logic              irq
);
   logic thr_pend;
   logic seen_rd, seen_pop;
   logic ovr_clr;

   assign ovr_clr = ovr_pend && (seen_rd || stat_rd) && (seen_pop || pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_pend <= 1'b0;
         ovr_pend <= 1'b0;
         seen_rd  <= 1'b0;
         seen_pop <= 1'b0;
      end else begin
         if (thr_evt)      thr_pend <= 1'b1;
         else if (stat_rd) thr_pend <= 1'b0;

         if (ovr_set) begin
            ovr_pend <= 1'b1;
            seen_rd  <= 1'b0;
            seen_pop <= 1'b0;
         end else if (ovr_clr) begin
            ovr_pend <= 1'b0;
            seen_rd  <= 1'b0;
            seen_pop <= 1'b0;
         end else if (ovr_pend) begin
            if (stat_rd) seen_rd  <= 1'b1;
            if (pop)     seen_pop <= 1'b1;
         end
      end
   end

   always_comb begin
      stat          = '0;
      stat[THR_BIT] = thr_pend;
      stat[OVR_BIT] = ovr_pend;
   end

   assign irq = |(stat & en);

   a_r7_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      thr_evt |=> stat[THR_BIT])
      else $error("threshold event lost");

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_pend && !stat_rd && !pop) |=> ovr_pend)
      else $error("overrun dropped without clear sequence");
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DEPTH     = 64,
   parameter bit          RESET_MEM = 1'b0,
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] sf_status,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   input  logic              stat_rd,
   output logic [BYTE_W-1:0] irq_status,
   input  logic [BYTE_W-1:0] irq_en,
   input  logic [CW-1:0]     thr_level,
   output logic [CW-1:0]     level,
   output logic              irq
);
   initial begin
      if (DEPTH < 2) $error("DEPTH must be at least 2");
   end

   logic full, empty, thr_evt, ovr_pend;
   logic pop, wr_acc, push, ovr_set;

   assign pop     = rd_en && !empty;
   assign wr_acc  = wr_en && !ovr_pend;
   assign push    = wr_acc && (!full || pop);
   assign ovr_set = wr_acc && full && !pop;

   rxq_store #(.DW(BYTE_W), .DEPTH(DEPTH), .RESET_MEM(RESET_MEM)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rd_en(rd_en),
      .ovr_wr(ovr_set), .wr_data(wr_data), .ovr_val(ovr_tag(sf_status)),
      .rd_q(rd_data)
   );

   rxq_level #(.DEPTH(DEPTH)) u_level (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .thr(thr_level),
      .count(level), .full(full), .empty(empty), .thr_evt(thr_evt)
   );

   rxq_irq u_irq (
      .clk(clk), .rst_n(rst_n), .thr_evt(thr_evt), .ovr_set(ovr_set),
      .pop(pop), .stat_rd(stat_rd), .en(irq_en), .stat(irq_status),
      .ovr_pend(ovr_pend), .irq(irq)
   );

   a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty && !wr_en) |=> (level == '0))
      else $error("empty read changed level");

   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_pend && !rd_en) |=> $stable(level))
      else $error("write accepted during overrun");

   a_r6_set_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_status[OVR_BIT]) |-> $past(full))
      else $error("overrun set while not full");
endmodule

// File: tb/sim_hdlc_rx_fifo.sv
module sim_hdlc_rx_fifo;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 0, rd_en = 0, stat_rd = 0;
   logic [7:0] wr_data = 0, sf_status = 0, irq_en = 0;
   logic [6:0] thr_level = 0;
   logic [7:0] rd_data, irq_status;
   logic [6:0] level;
   logic       irq;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hdlc_rx_fifo u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .sf_status(sf_status), .rd_en(rd_en), .rd_data(rd_data),
      .stat_rd(stat_rd), .irq_status(irq_status), .irq_en(irq_en),
      .thr_level(thr_level), .level(level), .irq(irq)
   );

   // behavioural reference
   byte unsigned q[$];
   byte unsigned m_rd = 0;
   bit m_thr = 0, m_ovr = 0, m_sr = 0, m_sp = 0;

   always @(posedge clk) begin
      if (rst_n) begin
         int old_n;
         bit pop, ovr_before, evt;
         old_n = q.size();
         ovr_before = m_ovr;
         pop = rd_en && (old_n > 0);
         if (rd_en) m_rd = pop ? q[0] : 8'h00;
         if (pop) void'(q.pop_front());
         if (wr_en && !ovr_before) begin
            if (old_n == DEPTH && !pop) begin
               q[q.size()-1] = sf_status | 8'h20;
               m_ovr = 1; m_sr = 0; m_sp = 0;
            end else q.push_back(wr_data);
         end
         if (ovr_before) begin
            if (stat_rd) m_sr = 1;
            if (pop)     m_sp = 1;
            if (m_sr && m_sp) begin m_ovr = 0; m_sr = 0; m_sp = 0; end
         end
         evt = (thr_level != 0) && (old_n < thr_level) && (q.size() >= thr_level);
         if (evt) m_thr = 1;
         else if (stat_rd) m_thr = 0;
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      bit [7:0] es;
      es = 0; es[3] = m_thr; es[5] = m_ovr;
      chk("R1 level", level, q.size());
      chk("R1 rd_data", rd_data, m_rd);
      chk("R6/R7 irq_status", irq_status, es);
      chk("R8 irq", irq, ((m_thr && irq_en[3]) || (m_ovr && irq_en[5])));
   endtask

   task automatic cyc(bit w, byte unsigned d, bit r, bit s);
      wr_en = w; wr_data = d; rd_en = r; stat_rd = s;
      @(negedge clk);
      wr_en = 0; rd_en = 0; stat_rd = 0;
      compare_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 level", level, 0);
      chk("R9 status", irq_status, 0);
      chk("R9 irq", irq, 0);
      chk("R9 rd_data", rd_data, 0);
      rst_n = 1;
      @(negedge clk);
      irq_en = 8'h28; thr_level = 4; sf_status = 8'h90;

      // threshold crossing
      cyc(1, 8'h11, 0, 0); cyc(1, 8'h22, 0, 0); cyc(1, 8'h33, 0, 0);
      chk("R7 below level", irq_status[3], 0);
      cyc(1, 8'h44, 0, 0);
      chk("R7 reach level", irq_status[3], 1);
      chk("R8 irq thr", irq, 1);
      cyc(0, 0, 0, 1);
      chk("R7 cleared by read", irq_status[3], 0);
      cyc(0, 0, 1, 0);
      chk("R1 oldest first", rd_data, 8'h11);
      cyc(1, 8'h55, 0, 0);
      chk("R7 re-crossing", irq_status[3], 1);
      cyc(0, 0, 0, 1);
      // simultaneous push + pop
      cyc(1, 8'h66, 1, 0);
      chk("R2 count held", level, 4);
      chk("R2 pop data", rd_data, 8'h22);
      chk("R2 no event", irq_status[3], 0);
      // drain and empty read
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
      chk("R1 last byte", rd_data, 8'h66);
      cyc(0, 0, 1, 0);
      chk("R3 empty data", rd_data, 0);
      chk("R3 empty level", level, 0);

      // mask and fill
      irq_en = 8'h00;
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(i + 1), 0, 0);
      chk("R8 masked thr", irq, 0);
      chk("R7 pending while masked", irq_status[3], 1);
      cyc(0, 0, 0, 1);
      // overflow
      cyc(1, 8'hEE, 0, 0);
      chk("R4 level full", level, DEPTH);
      chk("R6 ovr bit", irq_status[5], 1);
      chk("R8 masked ovr", irq, 0);
      irq_en = 8'h20;
      @(negedge clk); compare_all();
      chk("R8 unmasked ovr", irq, 1);
      cyc(1, 8'hAA, 0, 0); cyc(1, 8'hAB, 0, 0);
      chk("R5 writes dropped", level, DEPTH);
      cyc(0, 0, 0, 1);
      chk("R6 read alone", irq_status[5], 1);
      cyc(0, 0, 1, 0);
      chk("R6 read then pop", irq_status[5], 0);
      for (int i = 0; i < DEPTH - 1; i++) cyc(0, 0, 1, 0);
      chk("R4 newest replaced", rd_data, 8'hB0);

      // second overflow, pop before status read
      sf_status = 8'h01;
      for (int i = 0; i < DEPTH + 1; i++) cyc(1, 8'(i), 0, 0);
      chk("R4 second ovr", irq_status[5], 1);
      cyc(0, 0, 1, 0);
      chk("R6 pop alone", irq_status[5], 1);
      cyc(1, 8'h77, 0, 0);
      chk("R5 dropped after pop", level, DEPTH - 1);
      cyc(0, 0, 0, 1);
      chk("R6 pop then read", irq_status[5], 0);
      cyc(1, 8'h78, 0, 0);
      chk("R5 accepted after clear", level, DEPTH);
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0);
      chk("R1 tail byte", rd_data, 8'h78);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule